// File: doc/BRIEF.md
# IrDA SIR Pulse Modem

This block sits between a UART core that oversamples by sixteen and an infrared transceiver running slow-rate IrDA. It produces the sixteen-times baud tick that the UART core uses. In the transmit direction it watches the UART's serial output and sends one short light pulse for every zero bit. A one bit produces no pulse. In the receive direction it turns each short pulse from the transceiver back into a full-length zero bit for the UART's input.

The baud tick comes from a 16-bit divisor that is loaded one byte at a time, so the bit rate is the clock frequency divided by sixteen times the divisor. With a 14.7456 MHz clock, divisors 96, 48, 24, 16 and 8 give 9600, 19200, 38400, 57600 and 115200 baud. The pulse width has two modes: three sixteenths of a bit, or a fixed count of clock cycles (24 cycles, about 1.6 µs at 14.7456 MHz). Each direction has its own IR enable. A direction that is not in IR mode passes the raw serial level straight through, so a half-duplex link can put one direction in IR mode at a time. Both pins have their own polarity select. The character frame carried through the block is one start bit, eight data bits sent LSB first, and one stop bit.

Top module: `irsir_modem`

## Requirements
- R1: After reset the divisor is 96, so `baudTick` is high for one cycle in every 96. With both IR enables set and both polarities normal, `irTxPin` idles low and `uartRxd` idles high.
- R2: Writing `divByte` with `divLoadLo` sets divisor bits 7:0, and writing it with `divLoadHi` sets bits 15:8. `baudTick` then pulses once every divisor cycles. A divisor of 0 behaves as 1.
- R3: With transmit IR mode on and pulse mode 3/16 (`pulseFixed`=0), every zero bit of `uartTxd` gives exactly one active pulse of 3×divisor cycles. One bits give none.
- R4: A bit starts at the tick on which `uartTxd` changes, or every 16 ticks when the level stays the same. The pulse starts when the seventh tick after the bit start is taken. When `uartTxd` is changed right after a tick, the pin first goes active 7×divisor+1 cycles later, counted at the sampling edge.
- R5: With `pulseFixed`=1, each transmit pulse lasts PULSE_CYC cycles (default 24), whatever the divisor.
- R6: `txInvert`=1 inverts `irTxPin`: the idle level becomes 1 and a pulse drives 0.
- R7: With `txIrEn`=0, `irTxPin` equals `uartTxd` XOR `txInvert`, and no pulses are made.
- R8: With `rxIrEn`=1, an active level on `irRxPin` (high when `rxInvert`=0) drives `uartRxd` low 3 cycles later for 16×divisor cycles. A new pulse during that window restarts the full window. Otherwise `uartRxd` is high.
- R9: With `rxInvert`=1, a low level on `irRxPin` is the active pulse and a high level is idle.
- R10: With `rxIrEn`=0, `uartRxd` equals the synchronised `irRxPin` XOR `rxInvert`, 2 cycles after the pin changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modem clock |
| rstN | input | 1 | Active-low asynchronous reset |
| divByte | input | 8 | Byte written into the divisor |
| divLoadLo | input | 1 | Load `divByte` into divisor bits 7:0 |
| divLoadHi | input | 1 | Load `divByte` into divisor bits 15:8 |
| pulseFixed | input | 1 | 0: pulse of 3/16 bit, 1: fixed PULSE_CYC pulse |
| txIrEn | input | 1 | Transmit IR mode (0 = pass-through) |
| rxIrEn | input | 1 | Receive IR mode (0 = pass-through) |
| txInvert | input | 1 | Invert transmit pin |
| rxInvert | input | 1 | Receive pin active low |
| uartTxd | input | 1 | Serial output of the UART core |
| uartRxd | output | 1 | Serial input to the UART core |
| baudTick | output | 1 | Sixteen-times baud strobe |
| irTxPin | output | 1 | To the transceiver LED driver |
| irRxPin | input | 1 | From the transceiver detector |

## Verification
The hardest situation to reach from the ports is the phase alignment between the UART's bit boundaries and the modem's own tick count. If that alignment is wrong, a pulse still appears with the right width but in the wrong place in the bit. The driver therefore changes `uartTxd` only on the sampling edge where it sees `baudTick`, just as a UART core fed by this tick would. It then measures the cycle distance from each start bit to the first pulse. Runs of consecutive zeros (byte 0x00) test the bit boundaries where the level does not change. A second receive pulse that lands inside the stretch window tests the restart of that window.

// File: rtl/irsir_pkg.sv
package irsir_pkg;
  localparam int DIV_W = 16;
  localparam int BYTE_W = 8;
  localparam int PHASE_W = 4;
  localparam int PULSE_PHASE = 7;
  localparam int PCNT_W = DIV_W + 2;
  localparam int STR_W = DIV_W + PHASE_W;

  typedef struct packed {
    logic tick;
    logic pulseStart;
  } modemStrb_t;
endpackage

// File: rtl/irsir_ctrl.sv
module irsir_ctrl
  import irsir_pkg::*;
#(
  parameter int RESET_DIV = 96
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [BYTE_W-1:0]    divByte,
  input  logic                 loadLo,
  input  logic                 loadHi,
  input  logic                 uartTxd,
  output modemStrb_t           strb,
  output logic [DIV_W-1:0]     effDiv
);
  logic [DIV_W-1:0]   divReg;
  logic [DIV_W-1:0]   divCnt;
  logic [PHASE_W-1:0] phase;
  logic               txdPrev;
  logic               txEdge;
  logic               tick;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divReg <= DIV_W'(RESET_DIV);
    end else begin
      if (loadLo) divReg[BYTE_W-1:0] <= divByte;
      if (loadHi) divReg[DIV_W-1:BYTE_W] <= divByte;
    end
  end

  assign effDiv = (divReg == '0) ? DIV_W'(1) : divReg;
  assign tick   = (divCnt >= effDiv - DIV_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) divCnt <= '0;
    else if (tick) divCnt <= '0;
    else divCnt <= divCnt + DIV_W'(1);
  end

  assign txEdge = uartTxd ^ txdPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txdPrev <= 1'b1;
      phase   <= '0;
    end else begin
      txdPrev <= uartTxd;
      if (txEdge) phase <= '0;
      else if (tick) phase <= phase + PHASE_W'(1);
    end
  end

  assign strb.tick       = tick;
  assign strb.pulseStart = tick && !txEdge && !uartTxd &&
                           (phase == PHASE_W'(PULSE_PHASE - 1));

  // R2: a tick is followed by a quiet cycle when the divisor is above 2 and held
  p_tick_spacing_r2: assert property (@(posedge clk) disable iff (!rstN)
    tick && (effDiv > DIV_W'(2)) && !loadLo && !loadHi |=> !tick);

  // R4: without a level change, phase advances by one on each tick
  p_phase_walk_r4: assert property (@(posedge clk) disable iff (!rstN)
    tick && !txEdge |=> phase == $past(phase) + PHASE_W'(1));
endmodule

// File: rtl/irsir_dp.sv
module irsir_dp
  import irsir_pkg::*;
#(
  parameter int PULSE_CYC = 24
) (
  input  logic             clk,
  input  logic             rstN,
  input  modemStrb_t       strb,
  input  logic [DIV_W-1:0] effDiv,
  input  logic             uartTxd,
  input  logic             txIrEn,
  input  logic             pulseFixed,
  input  logic             txInvert,
  input  logic             rxIrEn,
  input  logic             rxInvert,
  input  logic             irRxPin,
  output logic             irTxPin,
  output logic             uartRxd
);
  logic [PCNT_W-1:0] pulseCnt;
  logic [PCNT_W-1:0] widthSel;
  logic              pulseOn;
  logic              sync1, sync2, rxPrev, rxLevel, rxRise;
  logic [STR_W-1:0]  stretchCnt;

  assign widthSel = pulseFixed ? PCNT_W'(PULSE_CYC)
                               : ({2'b00, effDiv} + {1'b0, effDiv, 1'b0});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pulseCnt <= '0;
    else if (!txIrEn) pulseCnt <= '0;
    else if (strb.pulseStart) pulseCnt <= widthSel;
    else if (pulseCnt != '0) pulseCnt <= pulseCnt - PCNT_W'(1);
  end

  assign pulseOn = (pulseCnt != '0);
  assign irTxPin = txIrEn ? (pulseOn ^ txInvert) : (uartTxd ^ txInvert);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sync1  <= 1'b0;
      sync2  <= 1'b0;
      rxPrev <= 1'b1;
    end else begin
      sync1  <= irRxPin;
      sync2  <= sync1;
      rxPrev <= rxLevel;
    end
  end

  assign rxLevel = sync2 ^ rxInvert;
  assign rxRise  = rxLevel & ~rxPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stretchCnt <= '0;
    else if (!rxIrEn) stretchCnt <= '0;
    else if (rxRise) stretchCnt <= {effDiv, {PHASE_W{1'b0}}};
    else if (stretchCnt != '0) stretchCnt <= stretchCnt - STR_W'(1);
  end

  assign uartRxd = rxIrEn ? (stretchCnt == '0) : rxLevel;

  // R3: a pulse only begins inside a zero bit
  p_pulse_in_zero_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pulseOn) |-> $past(!uartTxd));

  // R5: a running pulse counts down one per cycle
  p_pulse_countdown_r5: assert property (@(posedge clk) disable iff (!rstN)
    txIrEn && (pulseCnt > PCNT_W'(1)) && !strb.pulseStart
      |=> pulseCnt == $past(pulseCnt) - PCNT_W'(1));

  // R8: a detected receive pulse pulls the UART input low
  p_rx_stretch_r8: assert property (@(posedge clk) disable iff (!rstN)
    rxIrEn && rxRise |=> !uartRxd);
endmodule

// File: rtl/irsir_modem.sv
module irsir_modem
  import irsir_pkg::*;
#(
  parameter int RESET_DIV = 96,
  parameter int PULSE_CYC = 24
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [7:0]  divByte,
  input  logic        divLoadLo,
  input  logic        divLoadHi,
  input  logic        pulseFixed,
  input  logic        txIrEn,
  input  logic        rxIrEn,
  input  logic        txInvert,
  input  logic        rxInvert,
  input  logic        uartTxd,
  output logic        uartRxd,
  output logic        baudTick,
  output logic        irTxPin,
  input  logic        irRxPin
);
  modemStrb_t       strb;
  logic [DIV_W-1:0] effDiv;

  irsir_ctrl #(.RESET_DIV(RESET_DIV)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .divByte (divByte),
    .loadLo  (divLoadLo),
    .loadHi  (divLoadHi),
    .uartTxd (uartTxd),
    .strb    (strb),
    .effDiv  (effDiv)
  );

  irsir_dp #(.PULSE_CYC(PULSE_CYC)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .effDiv     (effDiv),
    .uartTxd    (uartTxd),
    .txIrEn     (txIrEn),
    .pulseFixed (pulseFixed),
    .txInvert   (txInvert),
    .rxIrEn     (rxIrEn),
    .rxInvert   (rxInvert),
    .irRxPin    (irRxPin),
    .irTxPin    (irTxPin),
    .uartRxd    (uartRxd)
  );

  assign baudTick = strb.tick;
endmodule

// File: tb/irsir_modem_tb.sv
`timescale 1ns/1ps
module irsir_modem_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] divByte = 8'h00;
  logic divLoadLo = 1'b0, divLoadHi = 1'b0;
  logic pulseFixed = 1'b0, txIrEn = 1'b1, rxIrEn = 1'b1;
  logic txInvert = 1'b0, rxInvert = 1'b0;
  logic uartTxd = 1'b1, irRxPin = 1'b0;
  logic uartRxd, baudTick, irTxPin;

  int tests = 0;
  int fails = 0;
  int expQ[$];
  bit monEn = 1'b0;
  string monReq = "R3";
  int curDiv = 96;

  always #2 clk = ~clk;

  irsir_modem u_dut (
    .clk(clk), .rstN(rstN), .divByte(divByte), .divLoadLo(divLoadLo),
    .divLoadHi(divLoadHi), .pulseFixed(pulseFixed), .txIrEn(txIrEn),
    .rxIrEn(rxIrEn), .txInvert(txInvert), .rxInvert(rxInvert),
    .uartTxd(uartTxd), .uartRxd(uartRxd), .baudTick(baudTick),
    .irTxPin(irTxPin), .irRxPin(irRxPin)
  );

  task automatic chk(input string req, input int act, input int exp, input string what);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  // monitor: measures each active transmit pulse and compares with the scoreboard
  int runLen = 0;
  always @(negedge clk) begin
    if (monEn) begin
      if (irTxPin ^ txInvert) runLen++;
      else if (runLen > 0) begin
        if (expQ.size() == 0) chk(monReq, runLen, 0, "unexpected pulse width");
        else chk(monReq, runLen, expQ.pop_front(), "pulse width");
        runLen = 0;
      end
    end else runLen = 0;
  end

  task automatic loadDiv(input int d);
    @(negedge clk); divByte = d[7:0]; divLoadLo = 1'b1;
    @(negedge clk); divLoadLo = 1'b0; divByte = d[15:8]; divLoadHi = 1'b1;
    @(negedge clk); divLoadHi = 1'b0;
    curDiv = (d == 0) ? 1 : d;
  endtask

  task automatic tickPeriod(output int p);
    int c;
    @(negedge clk);
    while (!baudTick) @(negedge clk);
    c = 0;
    do begin @(negedge clk); c++; end while (!baudTick);
    p = c;
  endtask

  // driver: sends one frame aligned to baud ticks and pushes expected pulse widths
  task automatic sendByte(input logic [7:0] b, input int width, input string req);
    logic [9:0] bits;
    int firstRise;
    bits = {1'b1, b, 1'b0};
    firstRise = -1;
    @(negedge clk);
    while (!baudTick) @(negedge clk);
    for (int i = 0; i < 10; i++) begin
      int cnt, ticks;
      uartTxd = bits[i];
      if (!bits[i]) expQ.push_back(width);
      cnt = 0; ticks = 0;
      while (ticks < 16) begin
        @(negedge clk); cnt++;
        if (i == 0 && firstRise < 0 && (irTxPin ^ txInvert)) firstRise = cnt;
        if (baudTick) ticks++;
      end
    end
    chk("R4", firstRise, 7 * curDiv + 1, "start-bit pulse offset");
    repeat (4) @(negedge clk);
    chk(req, expQ.size(), 0, "pulses left unseen");
    expQ.delete();
  endtask

  task automatic rxPulse(input int gap, input int expLow, input string req);
    int cnt, first, lowRun;
    bit done;
    logic act;
    act = ~rxInvert;
    cnt = 0; first = -1; lowRun = 0; done = 1'b0;
    @(negedge clk); irRxPin = act;
    while (!done && cnt < 5000) begin
      @(negedge clk); cnt++;
      if (cnt == 6) irRxPin = ~act;
      if (gap > 0 && cnt == gap) irRxPin = act;
      if (gap > 0 && cnt == gap + 6) irRxPin = ~act;
      if (!uartRxd) begin
        if (first < 0) first = cnt;
        lowRun++;
      end else if (first >= 0) done = 1'b1;
    end
    chk(req, first, 3, "receive latency");
    chk(req, lowRun, expLow, "receive low length");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int p;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1", irTxPin, 0, "idle transmit pin");
    chk("R1", uartRxd, 1, "idle receive output");
    tickPeriod(p); chk("R1", p, 96, "reset tick period");

    // R2: divisor loads
    loadDiv(256); tickPeriod(p); tickPeriod(p); chk("R2", p, 256, "high-byte divisor period");
    loadDiv(0);   tickPeriod(p); tickPeriod(p); chk("R2", p, 1, "zero divisor period");
    loadDiv(4);   tickPeriod(p); tickPeriod(p); chk("R2", p, 4, "divisor 4 period");

    // R3/R4: 3/16 pulses
    monEn = 1'b1; monReq = "R3";
    sendByte(8'hA5, 12, "R3");
    sendByte(8'h00, 12, "R3");
    sendByte(8'hFF, 12, "R3");

    // R5: fixed pulse width at divisor 8
    monEn = 1'b0; loadDiv(8); pulseFixed = 1'b1; monEn = 1'b1; monReq = "R5";
    sendByte(8'h3C, 24, "R5");

    // R6: inverted transmit pin
    monEn = 1'b0; loadDiv(4); pulseFixed = 1'b0; txInvert = 1'b1;
    @(negedge clk); chk("R6", irTxPin, 1, "inverted idle level");
    monEn = 1'b1; monReq = "R6";
    sendByte(8'h5A, 12, "R6");
    monEn = 1'b0;

    // R7: transmit pass-through
    txIrEn = 1'b0; uartTxd = 1'b0;
    @(negedge clk); chk("R7", irTxPin, 1, "pass-through zero inverted");
    txInvert = 1'b0;
    @(negedge clk); chk("R7", irTxPin, 0, "pass-through zero");
    uartTxd = 1'b1;
    @(negedge clk); chk("R7", irTxPin, 1, "pass-through one");
    txIrEn = 1'b1;

    // R8: receive stretch, single and restarted
    repeat (10) @(negedge clk);
    rxPulse(0, 64, "R8");
    repeat (10) @(negedge clk);
    rxPulse(40, 104, "R8");

    // R9: active-low receive pin
    rxInvert = 1'b1; irRxPin = 1'b1;
    repeat (100) @(negedge clk);
    chk("R9", uartRxd, 1, "idle with inverted receive");
    rxPulse(0, 64, "R9");

    // R10: receive pass-through
    rxIrEn = 1'b0; rxInvert = 1'b0; irRxPin = 1'b1;
    repeat (4) @(negedge clk);
    @(negedge clk); irRxPin = 1'b0;
    @(negedge clk); chk("R10", uartRxd, 1, "pass-through before sync");
    @(negedge clk); chk("R10", uartRxd, 0, "pass-through after sync");
    rxInvert = 1'b1;
    @(negedge clk); chk("R10", uartRxd, 1, "pass-through inverted");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule